// File: doc/BRIEF.md
# Vector Pack Unsigned-Saturate Unit

This unit narrows signed 32-bit vector elements from two sources into unsigned 16-bit words. Each element is clamped to the range 0x0000 to 0xFFFF. The narrowed words are interleaved lane by lane: inside every 128-bit lane, the four words from the first source come first, followed by the four words from the second source. A length select sets the active width to 128, 256 or 512 bits. The second source can be replaced by copies of one 32-bit scalar. Per-word write masking either keeps the old destination word or forces it to zero.

A compatibility mode reproduces the older two-operand form. In that mode the old destination value acts as the first source and the length is fixed at one lane. Destination bits above that lane keep their old contents. Operands are presented together with an `in_valid` strobe, and the packed result is registered one clock later together with `out_valid`. The unit is purely a datapath. It has no control states, so everything that is sequenced lives in the single valid/result register stage.

Top module: `vpack_usat`

## Requirements
- R1: Each 32-bit element is read as two's complement. A negative value gives 0x0000, a value above 0xFFFF gives 0xFFFF, and any other value passes its low 16 bits. For example, 0x80000000 gives 0x0000 and 0x00010000 gives 0xFFFF.
- R2: In lane L (bits 128L+127..128L), result word 8L+k for k = 0..3 is built from `src_a` element 4L+k. Result word 8L+4+k is built from `src_b` element 4L+k. Word j occupies bits 16j+15..16j, and element i occupies bits 32i+31..32i.
- R3: `vlen_sel` encodes the active length. 0 selects 128 bits (1 lane), 1 selects 256 bits (2 lanes) and 2 selects 512 bits (4 lanes). The unused code 3 behaves like 0.
- R4: When `bcast_en` is 1, every element of the second source is replaced by `bcast_val`, and `src_b` is ignored.
- R5: With `wmask_en` at 0, every active word is written. With `wmask_en` at 1, word j is written only when `wmask[j]` is 1. A word that is not written takes word j of `dst_old` when `zero_en` is 0, and takes 0x0000 when `zero_en` is 1.
- R6: Result bits above the active length are 0, whatever the mask and `dst_old` hold.
- R7: With `legacy_en` at 1:
  - the first source is `dst_old[127:0]`, and `src_a` is ignored;
  - the length is one lane;
  - masking and broadcast are ignored;
  - result bits above 127 equal `dst_old`.
- R8: `out_valid` equals the previous cycle's `in_valid`. `result` loads only on an edge where `in_valid` is 1 and otherwise holds.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 512 | First source, 16 signed 32-bit elements |
| src_b | input | 512 | Second source, 16 signed 32-bit elements |
| bcast_val | input | 32 | Scalar replicated into the second source when broadcasting |
| vlen_sel | input | 2 | Active length code (0: 128, 1: 256, 2: 512, 3: 128) |
| bcast_en | input | 1 | Replace the second source with `bcast_val` |
| wmask | input | 32 | Per-word write mask |
| wmask_en | input | 1 | Enable write masking |
| zero_en | input | 1 | Unwritten words become zero instead of keeping the old value |
| legacy_en | input | 1 | Two-operand compatibility mode |
| dst_old | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Packed, masked result |

## Verification
The bench builds the unit with its default parameters: a 512-bit maximum length, 128-bit lanes and 32-bit elements. This puts all three lengths and the unused length code in reach, including cases where two or three lanes must read as zero. Because there are 32 result words, every mask bit and the merge-versus-zero choice can be exercised in every lane. The compatibility mode can also be shown to preserve the full 384 upper bits of `dst_old`.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

    typedef enum logic [1:0] {
        VLEN_128 = 2'd0,
        VLEN_256 = 2'd1,
        VLEN_512 = 2'd2,
        VLEN_RSV = 2'd3
    } vlen_e;

    // Number of active 128-bit lanes for a length code, bounded by the build size.
    function automatic int lane_count(input logic [1:0] sel, input logic legacy,
                                      input int max_lanes);
        int n;
        if (legacy) begin
            n = 1;
        end else begin
            case (vlen_e'(sel))
                VLEN_256: n = 2;
                VLEN_512: n = 4;
                default:  n = 1;
            endcase
        end
        if (n > max_lanes) n = max_lanes;
        return n;
    endfunction

endpackage

// File: rtl/vpk_clamp.sv
module vpk_clamp #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam logic [IN_W-1:0] LIMIT = IN_W'(1) << OUT_W;
    localparam logic [IN_W-1:0] SIGNB = IN_W'(1) << (IN_W - 1);

    logic is_neg;
    logic is_big;

    always_comb begin
        is_neg = din[IN_W-1];
        is_big = !is_neg && (|din[IN_W-2:OUT_W]);
        if (is_neg)      dout = '0;
        else if (is_big) dout = '1;
        else             dout = din[OUT_W-1:0];
    end

    always_comb begin
        if (!$isunknown(din)) begin
            assert_pass_low_R1: assert (din >= LIMIT || dout == din[OUT_W-1:0]);
            assert_clamp_high_R1: assert (din < LIMIT || din >= SIGNB || dout == '1);
            assert_clamp_neg_R1: assert (din < SIGNB || dout == '0);
        end
    end

endmodule

// File: rtl/vpk_lane.sv
module vpk_lane #(
    parameter int LANE_W = 128,
    parameter int ELEM_W = 32
) (
    input  logic [LANE_W-1:0] lane_a,
    input  logic [LANE_W-1:0] lane_b,
    output logic [LANE_W-1:0] lane_y
);
    localparam int WORD_W = ELEM_W / 2;
    localparam int NE     = LANE_W / ELEM_W;

    for (genvar e = 0; e < NE; e++) begin : g_elem
        vpk_clamp #(.IN_W(ELEM_W), .OUT_W(WORD_W)) i_clamp_a (
            .din  (lane_a[e*ELEM_W +: ELEM_W]),
            .dout (lane_y[e*WORD_W +: WORD_W])
        );
        vpk_clamp #(.IN_W(ELEM_W), .OUT_W(WORD_W)) i_clamp_b (
            .din  (lane_b[e*ELEM_W +: ELEM_W]),
            .dout (lane_y[(NE+e)*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/vpk_mask.sv
module vpk_mask #(
    parameter int NWORDS = 32,
    parameter int WORD_W = 16
) (
    input  logic [NWORDS*WORD_W-1:0] packed_in,
    input  logic [NWORDS*WORD_W-1:0] old_in,
    input  logic [NWORDS-1:0]        mask,
    input  logic                     mask_on,
    input  logic                     zero_on,
    input  logic [NWORDS-1:0]        active,
    input  logic [NWORDS-1:0]        keep,
    output logic [NWORDS*WORD_W-1:0] merged
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_comb begin
            if (keep[w])
                merged[w*WORD_W +: WORD_W] = old_in[w*WORD_W +: WORD_W];
            else if (!active[w])
                merged[w*WORD_W +: WORD_W] = '0;
            else if (!mask_on || mask[w])
                merged[w*WORD_W +: WORD_W] = packed_in[w*WORD_W +: WORD_W];
            else if (zero_on)
                merged[w*WORD_W +: WORD_W] = '0;
            else
                merged[w*WORD_W +: WORD_W] = old_in[w*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/vpack_usat.sv
module vpack_usat #(
    parameter int VL_MAX = 512,
    parameter int LANE_W = 128,
    parameter int ELEM_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [VL_MAX-1:0]          src_a,
    input  logic [VL_MAX-1:0]          src_b,
    input  logic [ELEM_W-1:0]          bcast_val,
    input  logic [1:0]                 vlen_sel,
    input  logic                       bcast_en,
    input  logic [VL_MAX/(ELEM_W/2)-1:0] wmask,
    input  logic                       wmask_en,
    input  logic                       zero_en,
    input  logic                       legacy_en,
    input  logic [VL_MAX-1:0]          dst_old,
    output logic                       out_valid,
    output logic [VL_MAX-1:0]          result
);
    import vpk_pkg::*;

    localparam int WORD_W = ELEM_W / 2;
    localparam int NLANES = VL_MAX / LANE_W;
    localparam int NWORDS = VL_MAX / WORD_W;
    localparam int NELEM  = VL_MAX / ELEM_W;
    localparam int WPL    = LANE_W / WORD_W;

    logic [VL_MAX-1:0] first_src;
    logic [VL_MAX-1:0] second_src;
    logic [VL_MAX-1:0] packed_all;
    logic [VL_MAX-1:0] next_result;
    logic [NWORDS-1:0] word_active;
    logic [NWORDS-1:0] word_keep;
    logic              mask_on;
    int                n_lanes;

    always_comb begin
        first_src  = legacy_en ? dst_old : src_a;
        second_src = (bcast_en && !legacy_en) ? {NELEM{bcast_val}} : src_b;
        mask_on    = wmask_en && !legacy_en;
        n_lanes    = lane_count(vlen_sel, legacy_en, NLANES);
        for (int w = 0; w < NWORDS; w++) begin
            word_active[w] = (w / WPL) < n_lanes;
            word_keep[w]   = legacy_en && !((w / WPL) < n_lanes);
        end
    end

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        vpk_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) i_lane (
            .lane_a (first_src[l*LANE_W +: LANE_W]),
            .lane_b (second_src[l*LANE_W +: LANE_W]),
            .lane_y (packed_all[l*LANE_W +: LANE_W])
        );
    end

    vpk_mask #(.NWORDS(NWORDS), .WORD_W(WORD_W)) i_mask (
        .packed_in (packed_all),
        .old_in    (dst_old),
        .mask      (wmask),
        .mask_on   (mask_on),
        .zero_on   (zero_en),
        .active    (word_active),
        .keep      (word_keep),
        .merged    (next_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_result;
        end
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    assert_zero_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wmask_en && zero_en && !legacy_en && !wmask[0])
        |=> result[WORD_W-1:0] == '0);

    if (NLANES > 1) begin : g_upper_chk
        assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !legacy_en && vlen_sel == VLEN_128)
            |=> result[VL_MAX-1:LANE_W] == '0);
        assert_rsv_len_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !legacy_en && vlen_sel == VLEN_RSV)
            |=> result[VL_MAX-1:LANE_W] == '0);
        assert_legacy_upper_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && legacy_en)
            |=> result[VL_MAX-1:LANE_W] == $past(dst_old[VL_MAX-1:LANE_W]));
    end

endmodule

// File: tb/test_vpack_usat.sv
module test_vpack_usat;
    localparam int  VW     = 512;
    localparam int  NW     = 32;
    localparam time PERIOD = 8ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [VW-1:0]   src_a = '0;
    logic [VW-1:0]   src_b = '0;
    logic [31:0]     bcast_val = '0;
    logic [1:0]      vlen_sel = 2'd2;
    logic            bcast_en = 1'b0;
    logic [NW-1:0]   wmask = '0;
    logic            wmask_en = 1'b0;
    logic            zero_en = 1'b0;
    logic            legacy_en = 1'b0;
    logic [VW-1:0]   dst_old = '0;
    logic            out_valid;
    logic [VW-1:0]   result;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag  = "R9";
    bit    done     = 0;

    logic          m_valid;
    logic [VW-1:0] m_res;

    always #(PERIOD/2) clk = ~clk;

    vpack_usat i_vpack_usat (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .bcast_val(bcast_val), .vlen_sel(vlen_sel), .bcast_en(bcast_en),
        .wmask(wmask), .wmask_en(wmask_en), .zero_en(zero_en),
        .legacy_en(legacy_en), .dst_old(dst_old),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] corner(int k);
        case (k % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h0000_FFFF;
            3: return 32'h0001_0000;
            4: return 32'h8000_0000;
            default: return 32'h7FFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] pick();
        if ($urandom % 3 == 0) return corner(int'($urandom % 6));
        return $urandom;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = pick();
        return v;
    endfunction

    // Behavioural reference built from the requirement text.
    function automatic logic [VW-1:0] ref_pack();
        logic [VW-1:0] r;
        int nl;
        if (legacy_en) nl = 1;
        else if (vlen_sel == 2'd1) nl = 2;
        else if (vlen_sel == 2'd2) nl = 4;
        else nl = 1;
        for (int w = 0; w < NW; w++) begin
            int lane;
            int pos;
            int s;
            logic [31:0] e;
            logic [15:0] v;
            lane = w / 8;
            pos  = w % 8;
            if (lane >= nl) begin
                v = legacy_en ? dst_old[w*16 +: 16] : 16'h0;
            end else begin
                if (pos < 4)
                    e = legacy_en ? dst_old[(lane*4+pos)*32 +: 32] : src_a[(lane*4+pos)*32 +: 32];
                else
                    e = (bcast_en && !legacy_en) ? bcast_val : src_b[(lane*4+pos-4)*32 +: 32];
                s = $signed(e);
                if (s < 0) v = 16'h0;
                else if (s > 65535) v = 16'hFFFF;
                else v = e[15:0];
                if (!legacy_en && wmask_en && !wmask[w])
                    v = zero_en ? 16'h0 : dst_old[w*16 +: 16];
            end
            r[w*16 +: 16] = v;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_res   <= '0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) m_res <= ref_pack();
        end
    end

    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk({cur_tag, " out_valid (R8)"}, VW'(out_valid), VW'(m_valid));
            chk({cur_tag, " result"}, result, m_res);
        end
    end

    task automatic apply(string tag);
        cur_tag  = tag;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_modes();
        bcast_en = 0; wmask_en = 0; zero_en = 0; legacy_en = 0; vlen_sel = 2'd2;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R8 watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset clears outputs
        chk("R9 reset out_valid", VW'(out_valid), '0);
        chk("R9 reset result", result, '0);
        rst = 1'b0;

        // R1: corner values in every element
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < VW/32; i++) begin
                src_a[i*32 +: 32] = corner(k);
                src_b[i*32 +: 32] = corner(k + 1 + i);
            end
            apply("R1");
        end

        // R2: distinct in-range values expose ordering
        for (int i = 0; i < VW/32; i++) begin
            src_a[i*32 +: 32] = 32'(i + 1);
            src_b[i*32 +: 32] = 32'(16'h100 + i);
        end
        apply("R2");

        // R3: every length code
        for (int s = 0; s < 4; s++) begin
            vlen_sel = 2'(s);
            src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
            apply("R3");
        end

        // R6: upper bits zero even with merging mask and all-ones old value
        vlen_sel = 2'd0; dst_old = '1; wmask_en = 1; zero_en = 0; wmask = '0;
        apply("R6");
        vlen_sel = 2'd1; wmask = 32'h00FF_00FF;
        apply("R6");
        clear_modes();

        // R4: broadcast scalar replaces the second source
        bcast_en = 1;
        for (int k = 0; k < 6; k++) begin
            bcast_val = corner(k); src_b = rnd_vec(); src_a = rnd_vec();
            apply("R4");
        end
        clear_modes();

        // R5: merge and zero masking
        for (int k = 0; k < 8; k++) begin
            wmask_en = 1; zero_en = k[0]; wmask = $urandom;
            vlen_sel = 2'(k % 3);
            src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
            apply("R5");
        end
        clear_modes();

        // R7: legacy mode ignores src_a, mask, broadcast, length
        for (int k = 0; k < 4; k++) begin
            legacy_en = 1; wmask_en = 1; zero_en = k[0]; wmask = '0;
            bcast_en = 1; bcast_val = pick(); vlen_sel = 2'd2;
            src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
            apply("R7");
        end
        clear_modes();

        // R8: idle cycles with changing inputs must hold result
        in_valid = 1'b0; cur_tag = "R8";
        for (int k = 0; k < 4; k++) begin
            src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
            @(negedge clk);
        end

        // Mixed random traffic
        for (int k = 0; k < 400; k++) begin
            in_valid  = ($urandom % 5) != 0;
            src_a     = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
            bcast_val = pick();
            vlen_sel  = 2'($urandom % 4);
            bcast_en  = $urandom % 2;
            wmask     = $urandom;
            wmask_en  = $urandom % 2;
            zero_en   = $urandom % 2;
            legacy_en = ($urandom % 8) == 0;
            cur_tag   = "random R5";
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule